// File: doc/BRIEF.md
# One-Cold Mutual Exclusion Arbiter

This block hands one shared resource to at most one of `N` requesters (default 3). Every requester raises its own active-high request line and keeps it high for as long as it needs the resource. The block answers on a vector of active-low grants, one line per requester. At most one grant line is low at any time.

A grant is latched. It stays low while its own request stays high, whatever the other request lines do. When the holder drops its request, the grant moves to another requester that is already waiting. It moves in that same clock edge, with no idle cycle in between. Waiting requesters leave no record of who came first. The winner is therefore picked by a fixed rule: the lowest index wins. The same rule settles requests that rise together from the idle state.

The grant register updates on the rising clock edge. It is cleared to the idle state (all grants high) by an asynchronous active-low reset.

Top module: `mcx_arbiter`

## Requirements
- R1: After any clock edge at which every request line is low, every grant line is high (the idle state).
- R2: From idle, a single high request on line i drives grant line i low at the next rising edge. All other grant lines stay high. Bit i of `grant_n` always belongs to bit i of `req`.
- R3: While grant i is low and request i stays high, the grant vector does not change, whatever the other request lines do.
- R4: At no time are two or more grant lines low. The grant vector is either all ones or has exactly one zero.
- R5: When the held request falls and no other request is high, the grant vector returns to all ones at that edge.
- R6: When the held request falls while other requests are high, the lowest-index waiting requester receives the grant at that same edge, with no idle cycle in between.
- R7: When two or more requests are high at the same edge from idle, the lowest-index one is granted.
- R8: While `rst_n` is low, all grant lines are high, from the moment reset is asserted.
- R9: With N=3, the vector written as `grant_n[2:0]` follows 111, 110, 101, 011, 111 for this sequence: request 0; request 1 while 0 holds; release 0; request 2 while 1 holds; release 1; release 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronous to `clk` |
| req | input | N | Active-high request, one bit per requester |
| grant_n | output | N | Active-low grant, registered, at most one bit low |

## Verification
Release and re-grant can fall in the same cycle. The holder drops its request at the very edge where other requests are already high, so the block must give up the old grant and choose a new winner at once. The bench provokes this in two ways. In one, several requests build up behind a holder and the holder then releases. In the other, one requester drops while another raises its line in the same cycle. A behavioural model, updated every cycle, decides which index should own the grant after that edge. The bench then checks that no all-high cycle appears in between and that the lowest-index waiter wins.

// File: rtl/mcx_pkg.sv
package mcx_pkg;
  localparam int unsigned MCX_DEF_WAYS = 3;
endpackage

// File: rtl/mcx_pick.sv
module mcx_pick #(
  parameter int unsigned WAYS = 3
) (
  input  logic [WAYS-1:0] cand,
  output logic [WAYS-1:0] win
);
  // seen[i] is set when some candidate below index i is present
  logic [WAYS:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < WAYS; i++) begin : g_chain
    assign seen[i+1] = seen[i] | cand[i];
    assign win[i]    = cand[i] & ~seen[i];
  end
endmodule

// File: rtl/mcx_hold.sv
module mcx_hold #(
  parameter int unsigned WAYS = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [WAYS-1:0] req,
  input  logic [WAYS-1:0] win,
  output logic [WAYS-1:0] owner
);
  logic [WAYS-1:0] owner_q;
  logic [WAYS-1:0] owner_d;
  logic            keep;
  logic            owner_en;

  always_comb begin
    keep     = |(owner_q & req);
    owner_d  = keep ? owner_q : win;
    owner_en = (owner_d != owner_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= '0;
    end else if (owner_en) begin
      owner_q <= owner_d;
    end
  end

  assign owner = owner_q;

  // R3
  hold_keeps_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(owner_q & req)) |=> $stable(owner_q));
endmodule

// File: rtl/mcx_arbiter.sv
module mcx_arbiter #(
  parameter int unsigned N = mcx_pkg::MCX_DEF_WAYS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant_n
);
  logic [N-1:0] win;
  logic [N-1:0] owner;

  mcx_pick #(.WAYS(N)) u_pick (
    .cand (req),
    .win  (win)
  );

  mcx_hold #(.WAYS(N)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .win   (win),
    .owner (owner)
  );

  assign grant_n = ~owner;

  // R4
  single_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~grant_n));

  // R1
  idle_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> (grant_n == '1));

  // R6
  handover_no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_n != '1) && ((~grant_n & req) == '0) && (req != '0)) |=> (grant_n != '1));

  // R2
  grant_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_n == '1) && (req != '0)) |=> ($countones(~grant_n) == 1));
endmodule

// File: tb/mcx_arbiter_test.sv
module mcx_arbiter_test;
  localparam int N = 3;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] req;
  logic [N-1:0] grant_n;

  int checks;
  int errors;
  int holder;   // model: index of current owner, -1 when idle
  bit done;

  mcx_arbiter #(.N(N)) uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .grant_n (grant_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [N-1:0] model_vec();
    logic [N-1:0] v;
    v = '1;
    if (holder >= 0) v[holder] = 1'b0;
    return v;
  endfunction

  task automatic check(input string tag, input logic [N-1:0] exp_v);
    checks++;
    if (grant_n !== exp_v) begin
      errors++;
      $display("FAIL %s grant_n=%b expected=%b", tag, grant_n, exp_v);
    end
  endtask

  // model of the next edge, computed from the requirements
  task automatic model_edge(input logic [N-1:0] r);
    if (holder >= 0 && r[holder]) return;   // R3 hold
    holder = -1;
    for (int i = 0; i < N; i++) begin
      if (r[i]) begin holder = i; break; end // R6/R7 lowest index
    end
  endtask

  // drive at negedge, let one rising edge pass, check at next negedge
  task automatic step(input logic [N-1:0] r, input string tag);
    req = r;
    model_edge(r);
    @(negedge clk);
    check(tag, model_vec());
    if (~grant_n != '0 && $countones(~grant_n) > 1) begin
      errors++;
      $display("FAIL R4 grant_n=%b expected at most one low", grant_n);
    end
  endtask

  initial begin
    checks = 0; errors = 0; holder = -1; done = 0;
    rst_n = 1'b0; req = '0;
    #1;
    check("R8 reset asserted", '1);
    repeat (3) @(negedge clk);
    check("R8 reset held", '1);
    rst_n = 1'b1;
    step(3'b000, "R1 idle");
    // R2 lone requests
    for (int i = 0; i < N; i++) begin
      step(3'b001 << i, "R2 lone request");
      step(3'b000, "R5 release to idle");
    end
    // R9 documented sequence
    step(3'b001, "R9 step 110");
    step(3'b011, "R9/R3 hold with 1 waiting");
    step(3'b010, "R9 step 101");
    step(3'b110, "R9/R3 hold with 2 waiting");
    step(3'b100, "R9 step 011");
    step(3'b000, "R9 step 111");
    // R7 simultaneous rise
    step(3'b110, "R7 simultaneous 1,2");
    step(3'b000, "R5 release");
    step(3'b111, "R7 simultaneous all");
    // R3 other lines toggle while 0 holds
    step(3'b011, "R3 toggle");
    step(3'b101, "R3 toggle");
    step(3'b001, "R3 toggle");
    // R6 pending at release: 1 and 2 waiting, 0 releases
    step(3'b111, "R3 both waiting");
    step(3'b110, "R6 lowest waiting wins");
    step(3'b100, "R6 handover to 2");
    // R6 release and new request in the same cycle
    step(3'b001, "R6 drop and raise same cycle");
    step(3'b000, "R1 back to idle");
    // R8 asynchronous reset mid-grant
    step(3'b100, "R2 grant 2");
    #1 rst_n = 1'b0;
    #0.5;
    holder = -1;
    check("R8 async reset mid-grant", '1);
    @(negedge clk);
    rst_n = 1'b1;
    step(3'b000, "R1 after reset");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule